// File: doc/BRIEF.md
# Prioritized Reset State Manager

This block decides which chip-level reset sequence is running. Five already-synchronized single-bit requests arrive at it: power-up, brownout, watchdog, a keyed software command and the external user pin. When a request is admitted the block enters the matching reset state. It drives both the processor-reset and peripheral-reset outputs high for a programmable number of clock cycles, then returns to idle. The code of the source that caused the most recent reset stays visible on a 3-bit output.

Arbitration is not a plain priority encoder. In idle the highest pending request wins. While a reset is running, the active state decides which sources it admits. Power-up always restarts the sequence. Brownout restarts any state except power-up. A watchdog request preempts a software reset but is ignored during a user reset. Software and user requests are ignored during every active reset.

Top module: `rst_sequencer`

## Requirements
- R1: In idle, the highest pending request is entered. Priority runs power-up, brownout, watchdog, software, user. `lastCause` takes the code 0 power-up, 1 brownout, 2 watchdog, 3 software, 4 user.
- R2: `porReq` high at a clock edge enters the power-up reset state from any state and restarts the length count. `lastCause` becomes 0.
- R3: `bodReq` restarts the sequence as a brownout reset from idle and from every active state except power-up. During a power-up reset, `bodReq` is ignored.
- R4: A reset entered at edge t keeps its outputs high for exactly 2^(N+1) cycles. N is the value of `lenSel` sampled at that edge, and the block is idle afterwards.
- R5: `procRst` and `periphRst` are both high while a reset state is active. Both are low in idle.
- R6: During a user reset, watchdog requests and software commands are ignored.
- R7: During a software reset, a watchdog request preempts it and the block enters a watchdog reset (`lastCause` 2). The user pin is ignored.
- R8: During a watchdog reset, software commands and the user pin are ignored.
- R9: A software reset is requested only by `swCmd` high in a cycle where `swKey` equals 8'hA5. A command with any other key is ignored.
- R10: `lastCause` changes only at entry to a reset state. It holds its value in idle and through the rest of a sequence.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| porReq | input | 1 | Power-up reset request, highest priority |
| bodReq | input | 1 | Brownout reset request |
| wdtReq | input | 1 | Watchdog reset request |
| swCmd | input | 1 | Software reset command pulse |
| swKey | input | 8 | Key qualifying the software command (must be 8'hA5) |
| userReq | input | 1 | External user reset request |
| lenSel | input | 4 | Reset length selector N; a reset lasts 2^(N+1) cycles |
| procRst | output | 1 | Processor reset, high during any reset state |
| periphRst | output | 1 | Peripheral reset, high during any reset state |
| lastCause | output | 3 | Code of the source of the most recent reset |

## Verification
Several rules are checked by the assertions on every cycle. They cover the state-admission rules: a user reset is never left for watchdog or software, a software reset yields to a watchdog request, and a watchdog reset never drops to software or user. They also check that power-up always wins, that the length counter steps down by one, and that the cause code stays still between entries. Other properties need whole scenarios: the exact 2^(N+1) duration, the idle priority among simultaneous requests, the key qualification and the cause code seen at the ports. The bench shows these with directed cases and a long seeded random run, compared against a reference model written from the requirements.

// File: rtl/rst_seq_pkg.sv
package rst_seq_pkg;
  localparam int LEN_W = 4;
  localparam int CNT_W = (1 << LEN_W) + 1;
  localparam logic [7:0] SW_KEY = 8'hA5;

  typedef enum logic [2:0] {
    CAUSE_POR = 3'd0,
    CAUSE_BOD = 3'd1,
    CAUSE_WDT = 3'd2,
    CAUSE_SW  = 3'd3,
    CAUSE_USR = 3'd4
  } cause_t;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_POR,
    ST_BOD,
    ST_WDT,
    ST_SW,
    ST_USR
  } seq_state_t;

  typedef struct packed {
    logic   load;
    cause_t cause;
  } seq_strobe_t;
endpackage

// File: rtl/rst_seq_ctrl.sv
module rst_seq_ctrl
  import rst_seq_pkg::*;
#(
  parameter logic [7:0] KEY = SW_KEY
) (
  input  logic        clk,
  input  logic        porReq,
  input  logic        bodReq,
  input  logic        wdtReq,
  input  logic        swCmd,
  input  logic [7:0]  swKey,
  input  logic        userReq,
  input  logic        cntZero,
  output seq_strobe_t strb,
  output logic        inReset
);
  seq_state_t state, pickState, nextState;
  logic swValid;
  logic admitBod, admitWdt, admitSw, admitUsr;
  logic take;

  assign swValid  = swCmd && (swKey == KEY);
  assign admitBod = (state != ST_POR);
  assign admitWdt = (state == ST_IDLE) || (state == ST_SW);
  assign admitSw  = (state == ST_IDLE);
  assign admitUsr = (state == ST_IDLE);

  always_comb begin
    take       = 1'b1;
    pickState  = ST_IDLE;
    strb.cause = CAUSE_POR;
    if (porReq) begin
      pickState  = ST_POR;
      strb.cause = CAUSE_POR;
    end else if (bodReq && admitBod) begin
      pickState  = ST_BOD;
      strb.cause = CAUSE_BOD;
    end else if (wdtReq && admitWdt) begin
      pickState  = ST_WDT;
      strb.cause = CAUSE_WDT;
    end else if (swValid && admitSw) begin
      pickState  = ST_SW;
      strb.cause = CAUSE_SW;
    end else if (userReq && admitUsr) begin
      pickState  = ST_USR;
      strb.cause = CAUSE_USR;
    end else begin
      take = 1'b0;
    end
    strb.load = take;
  end

  always_comb begin
    if (take) nextState = pickState;
    else if ((state != ST_IDLE) && cntZero) nextState = ST_IDLE;
    else nextState = state;
  end

  always_ff @(posedge clk) state <= nextState;

  assign inReset = (state != ST_IDLE);

  // R2
  por_wins_chk: assert property (@(posedge clk) porReq |=> state == ST_POR);
  // R6
  usr_holds_chk: assert property (@(posedge clk) disable iff (porReq)
    (state == ST_USR && !bodReq) |=> (state == ST_USR || state == ST_IDLE));
  // R7
  wdt_over_sw_chk: assert property (@(posedge clk) disable iff (porReq)
    (state == ST_SW && wdtReq && !bodReq) |=> state == ST_WDT);
  // R8
  wdt_blocks_low_chk: assert property (@(posedge clk) disable iff (porReq)
    (state == ST_WDT) |=> (state != ST_SW && state != ST_USR));
  // R3
  bod_masked_in_por_chk: assert property (@(posedge clk) disable iff (porReq)
    (state == ST_POR) |=> (state == ST_POR || state == ST_IDLE));
endmodule

// File: rtl/rst_seq_dp.sv
module rst_seq_dp
  import rst_seq_pkg::*;
#(
  parameter int LW = LEN_W,
  localparam int CW = (1 << LW) + 1
) (
  input  logic          clk,
  input  logic          porReq,
  input  seq_strobe_t   strb,
  input  logic [LW-1:0] lenSel,
  output logic          cntZero,
  output logic [2:0]    lastCause
);
  logic [CW-1:0] cnt;
  logic [CW-1:0] loadVal;

  // terminal count 2^(len+1)-1 as a run of ones
  always_comb begin
    for (int i = 0; i < CW; i++) loadVal[i] = (i <= int'(lenSel));
  end

  always_ff @(posedge clk) begin
    if (strb.load) cnt <= loadVal;
    else if (cnt != '0) cnt <= cnt - 1'b1;
  end

  always_ff @(posedge clk) begin
    if (strb.load) lastCause <= strb.cause;
  end

  assign cntZero = (cnt == '0);

  // R4
  cnt_step_chk: assert property (@(posedge clk) disable iff (porReq)
    (!strb.load && cnt != '0) |=> cnt == $past(cnt) - 1'b1);
  // R10
  cause_stable_chk: assert property (@(posedge clk) disable iff (porReq)
    !strb.load |=> $stable(lastCause));
  // R1
  cause_range_chk: assert property (@(posedge clk) disable iff (porReq)
    strb.load |=> lastCause <= 3'd4);
endmodule

// File: rtl/rst_sequencer.sv
module rst_sequencer
  import rst_seq_pkg::*;
(
  input  logic       clk,
  input  logic       porReq,
  input  logic       bodReq,
  input  logic       wdtReq,
  input  logic       swCmd,
  input  logic [7:0] swKey,
  input  logic       userReq,
  input  logic [3:0] lenSel,
  output logic       procRst,
  output logic       periphRst,
  output logic [2:0] lastCause
);
  seq_strobe_t strb;
  logic cntZero;
  logic inReset;

  rst_seq_ctrl #(.KEY(SW_KEY)) u_ctrl (
    .clk(clk), .porReq(porReq), .bodReq(bodReq), .wdtReq(wdtReq),
    .swCmd(swCmd), .swKey(swKey), .userReq(userReq),
    .cntZero(cntZero), .strb(strb), .inReset(inReset)
  );

  rst_seq_dp #(.LW(LEN_W)) u_dp (
    .clk(clk), .porReq(porReq), .strb(strb), .lenSel(lenSel),
    .cntZero(cntZero), .lastCause(lastCause)
  );

  assign procRst   = inReset;
  assign periphRst = inReset;
endmodule

// File: tb/test_rst_sequencer.sv
module test_rst_sequencer;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0;
  logic porReq = 0, bodReq = 0, wdtReq = 0, swCmd = 0, userReq = 0;
  logic [7:0] swKey = 8'h00;
  logic [3:0] lenSel = 4'd0;
  logic procRst, periphRst;
  logic [2:0] lastCause;

  int checks = 0;
  int failures = 0;
  int cycles = 0;

  // model: 0 idle, 1 por, 2 bod, 3 wdt, 4 sw, 5 usr
  int mState = 0;
  int mCnt = 0;
  int mCause = 0;
  bit causeKnown = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  rst_sequencer i_rst_sequencer (
    .clk(clk), .porReq(porReq), .bodReq(bodReq), .wdtReq(wdtReq),
    .swCmd(swCmd), .swKey(swKey), .userReq(userReq), .lenSel(lenSel),
    .procRst(procRst), .periphRst(periphRst), .lastCause(lastCause)
  );

  function automatic int pickReq(int st, bit p, bit b, bit w, bit s, bit u);
    if (p) return 1;
    if (b && st != 1) return 2;
    if (w && (st == 0 || st == 4)) return 3;
    if (s && st == 0) return 4;
    if (u && st == 0) return 5;
    return 0;
  endfunction

  task automatic check(string tag, bit ok, int act, int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic step(string tag);
    int p;
    @(posedge clk);
    cycles++;
    p = pickReq(mState, porReq, bodReq, wdtReq, swCmd && swKey == 8'hA5, userReq);
    if (p != 0) begin
      mState = p;
      mCnt = (1 << (int'(lenSel) + 1)) - 1;
      mCause = p - 1;
      causeKnown = 1;
    end else if (mState != 0) begin
      if (mCnt == 0) mState = 0;
      else mCnt--;
    end
    @(negedge clk);
    check({tag, "/R5 procRst"}, procRst === (mState != 0), int'(procRst), int'(mState != 0));
    check({tag, "/R5 periphRst"}, periphRst === (mState != 0), int'(periphRst), int'(mState != 0));
    if (causeKnown)
      check({tag, "/R10 lastCause"}, lastCause === 3'(mCause), int'(lastCause), mCause);
  endtask

  task automatic clearIn();
    porReq = 0; bodReq = 0; wdtReq = 0; swCmd = 0; userReq = 0; swKey = 8'h00;
  endtask

  task automatic idleRun(string tag, int n);
    for (int i = 0; i < n; i++) step(tag);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired actual=%0d expected=0", cycles);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    int hi;
    void'($urandom(32'd1234));
    @(negedge clk);
    // R2: power-up reset state
    lenSel = 4'd0; porReq = 1;
    step("R2"); step("R2");
    check("R2 cause after por", lastCause === 3'd0, int'(lastCause), 0);
    check("R2 procRst in por", procRst === 1'b1, int'(procRst), 1);
    clearIn();
    idleRun("R2", 4);

    // R4: duration 2^(N+1) with N=3 -> 16 cycles
    lenSel = 4'd3; userReq = 1; step("R4"); clearIn(); lenSel = 4'd0;
    hi = 1;
    for (int i = 0; i < 30; i++) begin step("R4"); if (procRst) hi++; end
    check("R4 user reset length", hi == 16, hi, 16);

    // R1: simultaneous requests in idle
    wdtReq = 1; swCmd = 1; swKey = 8'hA5; userReq = 1; step("R1"); clearIn();
    check("R1 wdt beats sw and user", lastCause === 3'd2, int'(lastCause), 2);
    idleRun("R1", 4);
    swCmd = 1; swKey = 8'hA5; userReq = 1; step("R1"); clearIn();
    check("R1 sw beats user", lastCause === 3'd3, int'(lastCause), 3);
    idleRun("R1", 4);

    // R9: wrong key ignored
    swCmd = 1; swKey = 8'h5A; step("R9"); clearIn();
    check("R9 wrong key no reset", procRst === 1'b0, int'(procRst), 0);
    check("R9 wrong key cause kept", lastCause === 3'd3, int'(lastCause), 3);
    idleRun("R10", 3);

    // R6: user reset masks wdt and sw
    lenSel = 4'd3; userReq = 1; step("R6"); clearIn();
    step("R6"); wdtReq = 1; step("R6"); clearIn();
    swCmd = 1; swKey = 8'hA5; step("R6"); clearIn();
    check("R6 still user", lastCause === 3'd4, int'(lastCause), 4);
    idleRun("R6", 20);

    // R7: sw preempted by wdt, user ignored
    swCmd = 1; swKey = 8'hA5; step("R7"); clearIn();
    userReq = 1; step("R7"); clearIn();
    check("R7 user ignored in sw", lastCause === 3'd3, int'(lastCause), 3);
    wdtReq = 1; step("R7"); clearIn();
    check("R7 wdt preempts sw", lastCause === 3'd2, int'(lastCause), 2);
    // R8: within wdt, sw and user ignored
    swCmd = 1; swKey = 8'hA5; step("R8"); clearIn();
    userReq = 1; step("R8"); clearIn();
    check("R8 stays wdt", lastCause === 3'd2, int'(lastCause), 2);
    // R3: bod preempts wdt
    bodReq = 1; step("R3"); clearIn();
    check("R3 bod preempts wdt", lastCause === 3'd1, int'(lastCause), 1);
    idleRun("R3", 20);
    // R3: bod ignored during por
    porReq = 1; step("R3"); clearIn(); step("R3");
    bodReq = 1; step("R3"); clearIn();
    check("R3 bod masked in por", lastCause === 3'd0, int'(lastCause), 0);
    // R2: por restarts from bod
    idleRun("R3", 20);
    bodReq = 1; step("R2"); clearIn(); step("R2");
    porReq = 1; step("R2"); clearIn();
    check("R2 por preempts bod", lastCause === 3'd0, int'(lastCause), 0);
    idleRun("R2", 20);

    // random phase
    for (int i = 0; i < 4000; i++) begin
      porReq  = ($urandom % 400) == 0;
      bodReq  = ($urandom % 200) == 0;
      wdtReq  = ($urandom % 60) == 0;
      swCmd   = ($urandom % 40) == 0;
      swKey   = (($urandom % 4) != 0) ? 8'hA5 : 8'($urandom);
      userReq = ($urandom % 40) == 0;
      lenSel  = 4'($urandom % 3);
      step("R1 random");
    end
    clearIn();
    idleRun("R10", 20);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule